// File: doc/BRIEF.md
# Host Interrupt Status and Mask Register

This block is an 8-bit interrupt register that the host sees at a single address in a video decoder. A read from that address returns one status bit per interrupt source. A write to the same address loads the mask bits, which use the same bit positions. The block takes level conditions and one-cycle pulses from the decoder's internal engines. It drives one active-low interrupt line to the host.

The sources do not all follow the same rule:

- The decode-running bit follows the decoder's run level. Both of its edges raise the interrupt, and a read does not change the bit.
- The FIFO-ready bit is set when either the auxiliary FIFO or the user-data FIFO goes from not ready to ready. A read clears it. While the FIFO levels stay high it does not fire again.
- The remaining sources are sticky event bits. Each one is set by a pulse and cleared by a read.

Top module: `hostIrqReg`

## Requirements
- R1: After reset the read data is 0x00, the interrupt output is high (inactive) and every mask bit is 0.
- R2: Bit 0 of the read data equals the decode-running level sampled at the previous clock edge. A read never changes bit 0.
- R3: Every change of the decode-running level, 0 to 1 or 1 to 0, makes an edge-pending condition. That condition drives the interrupt low from the next cycle, unless mask bit 0 is set. A read clears the edge-pending condition.
- R4: Bit 1 is set one cycle after aux-ready or user-ready goes from 0 to 1. A read clears bit 1. While both levels are held, bit 1 stays clear and no further interrupt is raised.
- R5: Bits 2 (first slice start), 3 (sequence end), 4 (memory transfer done), 6 (audio sync recovery) and 7 (new field) are each set one cycle after their event pulse and cleared by a read. If a pulse arrives in the same cycle as a read, the bit stays set.
- R6: Bit 5 is reserved. It always reads 0, and its mask bit cannot be written.
- R7: The interrupt output is low exactly when some status condition is pending and its mask bit is 0. The pending condition for bit 0 is the edge-pending condition; for every other bit it is the status bit itself. A write loads mask bit i from write data bit i.
- R8: A write changes only the mask bits. It never changes any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Host read strobe; read-clear bits are cleared at this edge |
| wrEn | input | 1 | Host write strobe; loads the mask bits |
| wrData | input | 8 | Host write data (mask bit per position) |
| rdData | output | 8 | Status read data |
| decodeRun | input | 1 | Decoder running level |
| auxReady | input | 1 | Auxiliary FIFO has data (level) |
| userReady | input | 1 | User-data FIFO has data (level) |
| sliceStartPulse | input | 1 | First slice start code seen (one-cycle pulse) |
| seqEndPulse | input | 1 | Sequence end code seen (pulse) |
| xferDonePulse | input | 1 | Memory transfer finished (pulse) |
| audioSyncPulse | input | 1 | Audio sync recovered (pulse) |
| newFieldPulse | input | 1 | New display field (pulse) |
| irqN | output | 1 | Interrupt to host, active low |

## Verification
The sticky-bit sweep walks each of the five event pulses through both the masked and the unmasked state. It shows that every bit sits at its stated position and that each mask bit gates only its own source. It also fires a pulse in the same cycle as a read, which separates the rule that an event wins from a plain clear. The decode level is toggled in both directions with and without its mask. This separates the level bit from its edge-pending condition, because a read must clear the interrupt while bit 0 keeps its value. The FIFO levels are raised one after the other and then held high, which shows edge detection rather than level sensing and confirms that held data does not fire again.

// File: rtl/hostIrqPkg.sv
package hostIrqPkg;
  localparam int REG_W = 8;
  localparam int DEC_BIT = 0;
  localparam int FIFO_BIT = 1;
  localparam int RSV_BIT = 5;
  localparam int FIFO_N = 2;
  localparam logic [REG_W-1:0] STICKY_SEL = 8'hDC;

  typedef struct packed {
    logic rdClr;
    logic wrMask;
  } ctlStrobe_t;
endpackage

// File: rtl/hostIrqCtl.sv
module hostIrqCtl
  import hostIrqPkg::*;
(
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic       rstN,
  output ctlStrobe_t strobe
);
  always_comb begin
    strobe.rdClr  = rstN & rdEn;
    strobe.wrMask = rstN & wrEn;
  end
endmodule

// File: rtl/hostIrqDp.sv
module hostIrqDp
  import hostIrqPkg::*;
#(
  parameter int W = REG_W,
  parameter int FN = FIFO_N,
  parameter logic [W-1:0] STICKY = STICKY_SEL
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic [W-1:0]  wrData,
  input  logic [W-1:0]  evtPulse,
  input  logic          decodeRun,
  input  logic [FN-1:0] fifoReady,
  output logic [W-1:0]  rdData,
  output logic [W-1:0]  maskQ,
  output logic          irqN
);
  localparam logic [W-1:0] WR_ALLOW = ~(W'(1) << RSV_BIT);

  logic [W-1:0] statVec;
  logic [W-1:0] pendVec;
  logic [FN-1:0] fifoPrevQ;
  logic decLvlQ;
  logic decPendQ;
  logic fifoRise;

  assign fifoRise = |(fifoReady & ~fifoPrevQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoPrevQ <= '0;
      decLvlQ   <= 1'b0;
      decPendQ  <= 1'b0;
      maskQ     <= '0;
    end else begin
      fifoPrevQ <= fifoReady;
      decLvlQ   <= decodeRun;
      if (decodeRun != decLvlQ) decPendQ <= 1'b1;
      else if (strobe.rdClr)    decPendQ <= 1'b0;
      if (strobe.wrMask) maskQ <= wrData & WR_ALLOW;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == DEC_BIT) begin : g_dec
      assign statVec[i] = decLvlQ;
      assign pendVec[i] = decPendQ;
    end else if (i == FIFO_BIT) begin : g_fifo
      logic fifoQ;
      always_ff @(posedge clk) begin
        if (!rstN)             fifoQ <= 1'b0;
        else if (fifoRise)     fifoQ <= 1'b1;
        else if (strobe.rdClr) fifoQ <= 1'b0;
      end
      assign statVec[i] = fifoQ;
      assign pendVec[i] = fifoQ;
    end else if (STICKY[i]) begin : g_sticky
      logic stickQ;
      always_ff @(posedge clk) begin
        if (!rstN) stickQ <= 1'b0;
        else       stickQ <= evtPulse[i] | (stickQ & ~strobe.rdClr);
      end
      assign statVec[i] = stickQ;
      assign pendVec[i] = stickQ;
    end else begin : g_rsv
      assign statVec[i] = 1'b0;
      assign pendVec[i] = 1'b0;
    end
  end

  assign rdData = statVec;
  assign irqN   = ~|(pendVec & ~maskQ);
endmodule

// File: rtl/hostIrqReg.sv
module hostIrqReg
  import hostIrqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       decodeRun,
  input  logic       auxReady,
  input  logic       userReady,
  input  logic       sliceStartPulse,
  input  logic       seqEndPulse,
  input  logic       xferDonePulse,
  input  logic       audioSyncPulse,
  input  logic       newFieldPulse,
  output logic       irqN
);
  ctlStrobe_t strobe;
  logic [REG_W-1:0] evtPulse;
  logic [REG_W-1:0] maskQ;

  assign evtPulse = {newFieldPulse, audioSyncPulse, 1'b0, xferDonePulse,
                     seqEndPulse, sliceStartPulse, 2'b00};

  hostIrqCtl ctl_i (
    .rdEn(rdEn), .wrEn(wrEn), .rstN(rstN), .strobe(strobe)
  );

  hostIrqDp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .evtPulse(evtPulse), .decodeRun(decodeRun),
    .fifoReady({userReady, auxReady}),
    .rdData(rdData), .maskQ(maskQ), .irqN(irqN)
  );
endmodule

// File: rtl/hostIrqChk.sv
module hostIrqChk (
  input logic       clk,
  input logic       rstN,
  input logic       rdEn,
  input logic       decodeRun,
  input logic       auxReady,
  input logic       newFieldPulse,
  input logic [7:0] rdData,
  input logic [7:0] maskQ,
  input logic       irqN
);
  p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdData[5] == 1'b0 && maskQ[5] == 1'b0);

  p_dec_mirror_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> rdData[0] == $past(decodeRun));

  p_dec_edge_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (decodeRun != rdData[0] && !maskQ[0]) |=> !irqN);

  p_fifo_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(auxReady) |=> rdData[1]);

  p_sticky_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    newFieldPulse |=> rdData[7]);

  p_sticky_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !newFieldPulse) |=> !rdData[7]);

  p_unmasked_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && !maskQ[7]) |-> !irqN);
endmodule

bind hostIrqReg hostIrqChk chk_i (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .decodeRun(decodeRun),
  .auxReady(auxReady), .newFieldPulse(newFieldPulse),
  .rdData(rdData), .maskQ(maskQ), .irqN(irqN)
);

// File: tb/hostIrqReg_tb.sv
module hostIrqReg_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic decodeRun = 1'b0, auxReady = 1'b0, userReady = 1'b0;
  logic [7:0] evt = '0;
  logic irqN;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hostIrqReg dut_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .decodeRun(decodeRun), .auxReady(auxReady),
    .userReady(userReady), .sliceStartPulse(evt[2]), .seqEndPulse(evt[3]),
    .xferDonePulse(evt[4]), .audioSyncPulse(evt[6]),
    .newFieldPulse(evt[7]), .irqN(irqN)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] d);
    wrEn = 1'b1; wrData = d; tick(); wrEn = 1'b0;
  endtask

  task automatic hostRead(input string req, input logic [7:0] exp);
    rdEn = 1'b1;
    chk(req, {1'b0, rdData}, {1'b0, exp});
    tick(); rdEn = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 rdData", {1'b0, rdData}, 9'h000);
    chk("R1 irqN", {8'h0, irqN}, 9'h001);

    // R5/R7 sweep: each sticky bit, masked and unmasked
    for (int m = 0; m < 2; m++) begin
      for (int b = 2; b < 8; b++) begin
        if (b == 5) continue;
        hostWrite(m ? (8'h01 << b) : 8'h00);
        evt[b] = 1'b1; tick(); evt[b] = 1'b0;
        chk("R5 bit set", {1'b0, rdData}, {1'b0, 8'h01 << b});
        chk("R7 irq gating", {8'h0, irqN}, {8'h0, 1'(m)});
        hostRead("R5 read value", 8'h01 << b);
        chk("R5 cleared", {1'b0, rdData}, 9'h000);
        chk("R7 irq released", {8'h0, irqN}, 9'h001);
      end
    end
    hostWrite(8'h00);

    // R5 collision: pulse in same cycle as read keeps bit
    evt[3] = 1'b1; tick(); evt[3] = 1'b0;
    evt[3] = 1'b1; rdEn = 1'b1; tick(); evt[3] = 1'b0; rdEn = 1'b0;
    chk("R5 event wins over read", {1'b0, rdData}, 9'h008);
    hostRead("R5 clear after collision", 8'h08);

    // R2/R3 decode level, both edges, mask off then on
    for (int m = 0; m < 2; m++) begin
      hostWrite(m ? 8'h01 : 8'h00);
      for (int e = 0; e < 2; e++) begin
        decodeRun = ~decodeRun; tick();
        chk("R2 mirror", {1'b0, rdData}, {8'h0, decodeRun});
        chk("R3 edge irq", {8'h0, irqN}, {8'h0, 1'(m)});
        hostRead("R2 read", {7'h0, decodeRun});
        chk("R2 read keeps bit0", {1'b0, rdData}, {8'h0, decodeRun});
        chk("R3 read clears edge", {8'h0, irqN}, 9'h001);
      end
    end
    hostWrite(8'h00);

    // R4 FIFO edge detection and no re-fire
    auxReady = 1'b1; tick();
    chk("R4 aux rise", {1'b0, rdData}, 9'h002);
    chk("R4 irq", {8'h0, irqN}, 9'h000);
    hostRead("R4 read", 8'h02);
    repeat (4) tick();
    chk("R4 held no refire", {1'b0, rdData}, 9'h000);
    chk("R4 held irq", {8'h0, irqN}, 9'h001);
    userReady = 1'b1; tick();
    chk("R4 user rise", {1'b0, rdData}, 9'h002);
    hostRead("R4 read user", 8'h02);
    auxReady = 1'b0; userReady = 1'b0; tick();
    chk("R4 fall no set", {1'b0, rdData}, 9'h000);

    // R6 reserved mask bit not writable; R8 write keeps status
    evt[7] = 1'b1; tick(); evt[7] = 1'b0;
    hostWrite(8'hFF);
    chk("R8 write keeps status", {1'b0, rdData}, 9'h080);
    chk("R7 all masked", {8'h0, irqN}, 9'h001);
    hostWrite(8'h20);
    chk("R6 reserved mask ignored", {8'h0, irqN}, 9'h000);
    chk("R6 bit5 reads 0", {8'h0, rdData[5]}, 9'h000);
    hostRead("R8 read", 8'h80);
    chk("R7 released", {8'h0, irqN}, 9'h001);
    summary();
  end
endmodule